// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers the event conditions of a serial flash/peripheral interface controller into one sticky status register, masks that register with an enable register and drives a single active-high, level-sensitive interrupt line. Each event input that is high in a cycle sets its status bit at the next clock edge. The bit then stays set until software writes a one to the matching position of a separate clear offset.

The event vector mixes one-shot events, such as the all-done trigger, with level conditions that track FIFO occupancy. A level condition that is still true sets its bit again in the same cycle that a clear write arrives. A clear followed by a read therefore samples the live condition, so software can poll FIFO state without taking interrupts. Out of reset only the illegal-access source is enabled. A soft-reset input wipes the status but keeps the enables.

Access uses a plain register port: a write strobe, an address, write data and a combinational read-data output. Bus protocol wrappers sit outside the block.

Top module: `irq_status_ctrl`

## Requirements
- R1: Byte offset 0x30 reads the status register and 0x34 reads and writes the enable register. A write to 0x38 is the clear command. Reads of 0x38 and of any other offset return zero, and only bits that exist can be written into the enable register.
- R2: Status and enable bits have fixed positions: 0 tx trigger, 1 tx empty, 2 tx half-full, 3 tx full, 5 rx trigger, 6 rx holds a word, 7 rx half-full, 8 rx full, 9 all-done, 11 rx holds a byte, 12 illegal access. Event input bit n feeds status bit n.
- R3: An event input high at a clock edge sets its status bit at that edge, and the bit stays set after the event drops.
- R4: Writing to the clear offset clears every status bit whose write-data bit is one and leaves the bits written as zero unchanged.
- R5: When an event and a clear of the same bit fall in the same cycle, the bit stays set. A clear-then-read sequence therefore returns the live level of a condition.
- R6: irq_o is high exactly while at least one status bit and its enable bit are both set.
- R7: After the asynchronous reset, status is zero, enable reads 0x0000_1000 (illegal access only) and irq_o is low.
- R8: A status read returns the raw status whatever the enables hold. Bits 4 and 10, and all bits above 12, always read as zero, even when their event input is driven high.
- R9: soft_rst_i clears every status bit at the next edge and takes priority over events in that cycle. The enable register is not changed by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous clear of all status bits |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| event_i | input | 13 | Event and level conditions, one per status bit |
| irq_o | output | 1 | Level-high interrupt request |

## Verification
Single-cycle pulses on a few sources separate stickiness from level following. Holding a level source across a clear write separates set-wins from clear-wins. Driving every event input high at once shows which positions exist and that bits 4 and 10 stay empty. Enable patterns that cover and miss the pending bits show that irq_o follows only the masked status while the status read stays raw. A soft reset issued while an event is active shows that the reset has priority and that the enables survive it.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned REG_DW = 32;
  localparam int unsigned OFS_W  = 8;
  localparam int unsigned SRC_W  = 13;

  localparam logic [OFS_W-1:0] OFS_STATUS = 8'h30;
  localparam logic [OFS_W-1:0] OFS_ENABLE = 8'h34;
  localparam logic [OFS_W-1:0] OFS_CLEAR  = 8'h38;

  localparam int unsigned B_TX_TRIG  = 0;
  localparam int unsigned B_TX_EMPTY = 1;
  localparam int unsigned B_TX_HALF  = 2;
  localparam int unsigned B_TX_FULL  = 3;
  localparam int unsigned B_RX_TRIG  = 5;
  localparam int unsigned B_RX_WORD  = 6;
  localparam int unsigned B_RX_HALF  = 7;
  localparam int unsigned B_RX_FULL  = 8;
  localparam int unsigned B_ALL_DONE = 9;
  localparam int unsigned B_RX_BYTE  = 11;
  localparam int unsigned B_BAD_ACC  = 12;

  localparam logic [SRC_W-1:0] SRC_VALID =
      SRC_W'((1 << B_TX_TRIG) | (1 << B_TX_EMPTY) | (1 << B_TX_HALF) |
             (1 << B_TX_FULL) | (1 << B_RX_TRIG)  | (1 << B_RX_WORD) |
             (1 << B_RX_HALF) | (1 << B_RX_FULL)  | (1 << B_ALL_DONE) |
             (1 << B_RX_BYTE) | (1 << B_BAD_ACC));

  localparam logic [SRC_W-1:0] EN_RESET = SRC_W'(1 << B_BAD_ACC);

  typedef struct packed {
    logic wr_enable;
    logic wr_clear;
    logic rd_status;
    logic rd_enable;
  } reg_sel_t;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_status_pkg::*;
#(
  parameter int unsigned ADDR_W = OFS_W
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_t          sel_o
);
  always_comb begin
    sel_o           = '0;
    sel_o.rd_status = (addr_i == ADDR_W'(OFS_STATUS));
    sel_o.rd_enable = (addr_i == ADDR_W'(OFS_ENABLE));
    sel_o.wr_enable = we_i && (addr_i == ADDR_W'(OFS_ENABLE));
    sel_o.wr_clear  = we_i && (addr_i == ADDR_W'(OFS_CLEAR));
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_status_pkg::*;
#(
  parameter int unsigned      NSRC  = SRC_W,
  parameter logic [NSRC-1:0]  VALID = SRC_VALID
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wipe_i,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] sts_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    if (VALID[i]) begin : g_impl
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q <= 1'b0;
        else if (wipe_i) q <= 1'b0;
        else             q <= set_i[i] | (q & ~clr_i[i]);  // set wins
      end
      assign sts_o[i] = q;
    end else begin : g_rsvd
      assign sts_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irq_status_pkg::*;
#(
  parameter int unsigned      NSRC   = SRC_W,
  parameter logic [NSRC-1:0]  VALID  = SRC_VALID,
  parameter logic [NSRC-1:0]  EN_RST = EN_RESET
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [NSRC-1:0] wdata_i,
  input  logic [NSRC-1:0] sts_i,
  output logic [NSRC-1:0] en_o,
  output logic            irq_o
);
  logic [NSRC-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= EN_RST & VALID;
    else if (wr_i) en_q <= wdata_i & VALID;
  end

  assign en_o  = en_q;
  assign irq_o = |(sts_i & en_q);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int unsigned      ADDR_W = OFS_W,
  parameter int unsigned      DATA_W = REG_DW,
  parameter int unsigned      NSRC   = SRC_W,
  parameter logic [NSRC-1:0]  VALID  = SRC_VALID,
  parameter logic [NSRC-1:0]  EN_RST = EN_RESET
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [NSRC-1:0]   event_i,
  output logic              irq_o
);
  localparam int unsigned PAD_W = DATA_W - NSRC;

  reg_sel_t        sel;
  logic [NSRC-1:0] sts_q;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] clr_vec;

  irq_addr_decode #(.ADDR_W(ADDR_W)) i_dec (
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .sel_o  (sel)
  );

  assign clr_vec = sel.wr_clear ? reg_wdata_i[NSRC-1:0] : '0;

  irq_status_bank #(.NSRC(NSRC), .VALID(VALID)) i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wipe_i (soft_rst_i),
    .set_i  (event_i),
    .clr_i  (clr_vec),
    .sts_o  (sts_q)
  );

  irq_mask_unit #(.NSRC(NSRC), .VALID(VALID), .EN_RST(EN_RST)) i_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (sel.wr_enable),
    .wdata_i (reg_wdata_i[NSRC-1:0]),
    .sts_i   (sts_q),
    .en_o    (en_q),
    .irq_o   (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (sel.rd_status)      reg_rdata_o = {{PAD_W{1'b0}}, sts_q};
    else if (sel.rd_enable) reg_rdata_o = {{PAD_W{1'b0}}, en_q};
  end
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_status_pkg::*;
#(
  parameter int unsigned      ADDR_W = OFS_W,
  parameter int unsigned      DATA_W = REG_DW,
  parameter int unsigned      NSRC   = SRC_W,
  parameter logic [NSRC-1:0]  VALID  = SRC_VALID
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [NSRC-1:0]   event_i,
  input logic              irq_o,
  input logic [NSRC-1:0]   sts_q,
  input logic [NSRC-1:0]   en_q
);
  logic clr_wr, en_wr;
  assign clr_wr = reg_we_i && (reg_addr_i == ADDR_W'(OFS_CLEAR));
  assign en_wr  = reg_we_i && (reg_addr_i == ADDR_W'(OFS_ENABLE));

  AST_EVENT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_rst_i |=> ((sts_q & $past(event_i & VALID)) == $past(event_i & VALID))); // R5

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst_i && !clr_wr) |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R3

  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !soft_rst_i) |=>
      ((sts_q & $past(reg_wdata_i[NSRC-1:0] & ~event_i)) == '0)); // R4

  AST_SOFT_WIPES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (sts_q == '0)); // R9

  AST_SOFT_KEEPS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_i && !en_wr) |=> (en_q == $past(en_q))); // R9

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((sts_q & en_q) != '0)); // R6

  AST_PEND_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_q & en_q) != '0) |-> irq_o); // R6

  AST_RSVD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_q | en_q) & ~VALID) == '0); // R8
endmodule

bind irq_status_ctrl irq_status_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(NSRC), .VALID(VALID)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .soft_rst_i  (soft_rst_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .event_i     (event_i),
  .irq_o       (irq_o),
  .sts_q       (sts_q),
  .en_q        (en_q)
);

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [12:0] ev = '0;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  irq_status_ctrl i_irq_status_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .event_i(ev), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse(input logic [12:0] v);
    @(negedge clk); ev = v;
    @(negedge clk); ev = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h30, d); chk("R7 status after reset", d, 32'h0);
    rd(8'h34, d); chk("R7 enable after reset", d, 32'h0000_1000);
    chk("R7 irq after reset", {31'b0, irq}, 32'h0);
    rd(8'h38, d); chk("R1 clear offset reads zero", d, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse(13'h0241);  // tx trigger, rx word, all-done
    rd(8'h30, d); chk("R3 sticky after pulse", d, 32'h0000_0241);
    repeat (3) @(negedge clk);
    rd(8'h30, d); chk("R2 bit positions held", d, 32'h0000_0241);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(8'h38, 32'h0000_0040);
    rd(8'h30, d); chk("R4 one-bit clear", d, 32'h0000_0201);
    wr(8'h38, 32'h0000_0201);
    rd(8'h30, d); chk("R4 clear rest", d, 32'h0);
  endtask

  task automatic t_live_poll();
    logic [31:0] d;
    @(negedge clk); ev = 13'h0008;  // tx full held
    wr(8'h38, 32'h0000_0008);
    rd(8'h30, d); chk("R5 set wins over clear", d, 32'h0000_0008);
    @(negedge clk); ev = '0;
    wr(8'h38, 32'h0000_0008);
    rd(8'h30, d); chk("R5 poll sees dropped level", d, 32'h0);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    pulse(13'h1FFF);
    rd(8'h30, d); chk("R8 reserved bits zero", d, 32'h0000_1BEF);
    wr(8'h34, 32'hFFFF_FFFF);
    rd(8'h34, d); chk("R1 enable writable bits", d, 32'h0000_1BEF);
    rd(8'h3C, d); chk("R1 unmapped offset zero", d, 32'h0);
    wr(8'h34, 32'h0000_1000);
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h30, d); chk("R4 clear all", d, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    pulse(13'h0001);
    rd(8'h30, d); chk("R8 raw status when masked", d, 32'h0000_0001);
    chk("R6 masked bit no irq", {31'b0, irq}, 32'h0);
    wr(8'h34, 32'h0000_1001);
    #1 chk("R6 enabled bit raises irq", {31'b0, irq}, 32'h1);
    wr(8'h38, 32'h0000_0001);
    #1 chk("R6 irq drops on clear", {31'b0, irq}, 32'h0);
    pulse(13'h1000);
    #1 chk("R6 illegal access irq", {31'b0, irq}, 32'h1);
    wr(8'h38, 32'h0000_1000);
    #1 chk("R6 irq low again", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_soft();
    logic [31:0] d;
    wr(8'h34, 32'h0000_0041);
    pulse(13'h0041);
    #1 chk("R6 irq before soft reset", {31'b0, irq}, 32'h1);
    @(negedge clk); soft_rst = 1'b1; ev = 13'h0002;
    @(negedge clk); soft_rst = 1'b0; ev = '0;
    rd(8'h30, d); chk("R9 soft reset wipes status", d, 32'h0);
    rd(8'h34, d); chk("R9 enable kept", d, 32'h0000_0041);
    chk("R9 irq low after soft reset", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sticky();
    t_clear();
    t_live_poll();
    t_reserved();
    t_irq();
    t_soft();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule